// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block moves 18-bit words between two ports, A and B, with a separate storage register for each direction. In each direction the stored word can follow its input transparently, hold its last value, or capture the input on the falling edge of a per-direction strobe. Which of these happens is set by a level-sensitive pass-through control and by the strobe. The A-to-B output enable is active high. The B-to-A output enable is active low.

Each port is exposed as a separate input vector, output vector and drive flag, so the block contains no tri-state logic. A wrapper at the chip boundary can resolve these onto shared pins. Everything runs on one fast system clock. The per-direction strobes are sampled on that clock, and a falling strobe is detected as "high at the previous sample, low now". The transparent path is a combinational bypass around the stored word, so no level-sensitive latch is inferred.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, `b_drive` and `a_drive` are 0. Both stored words clear to zero, so with both pass-through controls low, `b_out` and `a_out` read 0 after reset.
- R2: While `ab_pass` is 1, `b_out` equals `a_in` in the same cycle, with no register in the path.
- R3: When `ab_pass` goes from 1 to 0, `b_out` shows the `a_in` value that was present at the last system-clock edge where `ab_pass` was 1.
- R4: While `ab_pass` is 0 and `ab_strobe` stays at a constant level, `b_out` keeps its value whatever `a_in` does.
- R5: While `ab_pass` is 0, a high-to-low change of `ab_strobe` between two system-clock samples loads `a_in` into storage. The new value appears on `b_out` after that clock edge.
- R6: A low-to-high change of `ab_strobe` leaves the A-to-B stored word unchanged. A falling strobe while `ab_pass` is 1 has no effect beyond the transparent update.
- R7: Out of reset, `b_drive` equals `ab_oe`, so the enable is active high.
- R8: The B-to-A direction follows R2 to R6, using `ba_pass`, `ba_strobe`, `b_in` and `a_out`.
- R9: Out of reset, `a_drive` is 1 exactly when `ba_oe_n` is 0, so the enable is active low.
- R10: The two directions are independent: no input of one direction changes the output or the stored word of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| a_in | input | 18 | Data arriving on port A |
| b_in | input | 18 | Data arriving on port B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_pass | input | 1 | A-to-B transparent-mode control |
| ab_strobe | input | 1 | A-to-B capture strobe, acts on its falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_pass | input | 1 | B-to-A transparent-mode control |
| ba_strobe | input | 1 | B-to-A capture strobe, acts on its falling edge |
| b_out | output | 18 | Word offered to port B |
| b_drive | output | 1 | Port B driver enable |
| a_out | output | 18 | Word offered to port A |
| a_drive | output | 1 | Port A driver enable |

## Verification
The bench first applies directed sequences:
- A pass-through run with changing data, which separates the combinational bypass from a registered copy.
- A drop of the pass-through control, which shows which sample is kept.
- A strobe that rises and then falls with fresh data at each step, which separates rising-edge capture from falling-edge capture.
- A falling strobe while pass-through is active.

It then sweeps all four combinations of the two enable levels, which catches an inverted polarity in either direction. Finally, a long run with random data and controls in both directions is compared every cycle against a reference model. This run exposes any coupling between the directions and any mode priority error.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ba_oe_n,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);

  logic [W-1:0] ab_word, ba_word;
  logic         ab_strobe_q, ba_strobe_q;
  logic         ab_fall, ba_fall;

  assign ab_fall = ab_strobe_q & ~ab_strobe;
  assign ba_fall = ba_strobe_q & ~ba_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_word     <= '0;
      ab_strobe_q <= 1'b0;
    end else begin
      ab_strobe_q <= ab_strobe;
      if (ab_pass || ab_fall) ab_word <= a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_word     <= '0;
      ba_strobe_q <= 1'b0;
    end else begin
      ba_strobe_q <= ba_strobe;
      if (ba_pass || ba_fall) ba_word <= b_in;
    end
  end

  assign b_out   = ab_pass ? a_in : ab_word;
  assign a_out   = ba_pass ? b_in : ba_word;
  assign b_drive = rst_n & ab_oe;
  assign a_drive = rst_n & ~ba_oe_n;

  assert_pass_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ab_pass) && !ab_pass |-> b_out == $past(a_in));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_pass && $past(!ab_pass && !ab_fall) |-> $stable(b_out));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_pass && $past(!ab_pass && ab_fall) |-> b_out == $past(a_in));

  assert_ba_pass_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ba_pass) && !ba_pass |-> a_out == $past(b_in));

  assert_ba_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_pass && $past(!ba_pass && !ba_fall) |-> $stable(a_out));

endmodule

// File: tb/sim_regbus_xcvr.sv
module sim_regbus_xcvr;
  localparam int W = 18;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe = 1, ab_pass = 0, ab_strobe = 0;
  logic ba_oe_n = 0, ba_pass = 0, ba_strobe = 0;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int errors = 0, checks = 0, contention = 0;
  bit done = 0;

  always #4 clk = ~clk;

  regbus_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_pass(ab_pass), .ab_strobe(ab_strobe),
    .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_strobe(ba_strobe),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive));

  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic m_abq = 0, m_baq = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ab <= '0; m_ba <= '0; m_abq <= 0; m_baq <= 0;
    end else begin
      if (ab_pass || (m_abq && !ab_strobe)) m_ab <= a_in;
      if (ba_pass || (m_baq && !ba_strobe)) m_ba <= b_in;
      m_abq <= ab_strobe;
      m_baq <= ba_strobe;
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " b_out"},   b_out,  ab_pass ? a_in : m_ab);
    chk({tag, " a_out"},   a_out,  ba_pass ? b_in : m_ba);
    chk({tag, " b_drive"}, W'(b_drive), W'(rst_n & ab_oe));
    chk({tag, " a_drive"}, W'(a_drive), W'(rst_n & ~ba_oe_n));
    if (a_drive && b_drive) contention++;
  endtask

  task automatic step_ab(logic [W-1:0] d, logic p, logic s, string tag);
    @(negedge clk);
    a_in = d; ab_pass = p; ab_strobe = s;
    #2 check_all(tag);
  endtask

  task automatic step_ba(logic [W-1:0] d, logic p, logic s, string tag);
    @(negedge clk);
    b_in = d; ba_pass = p; ba_strobe = s;
    #2 check_all(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    a_in = 18'h2AAAA; b_in = 18'h15555;
    #2;
    chk("R1 b_drive in reset", W'(b_drive), '0);
    chk("R1 a_drive in reset", W'(a_drive), '0);
    @(negedge clk); rst_n = 1;
    #2;
    chk("R1 b_out after reset", b_out, '0);
    chk("R1 a_out after reset", a_out, '0);

    step_ab(18'h12345, 1, 0, "R2");
    chk("R2 same-cycle bypass", b_out, 18'h12345);
    step_ab(18'h0F0F0, 1, 0, "R2");
    chk("R2 follows new data", b_out, 18'h0F0F0);
    step_ab(18'h3FFFF, 0, 0, "R3");
    chk("R3 keeps last pass sample", b_out, 18'h0F0F0);
    step_ab(18'h00001, 0, 0, "R4");
    step_ab(18'h2BEEF, 0, 0, "R4");
    chk("R4 hold strobe low", b_out, 18'h0F0F0);
    step_ab(18'h11111, 0, 1, "R6");
    step_ab(18'h22222, 0, 1, "R6");
    chk("R6 rising strobe ignored", b_out, 18'h0F0F0);
    step_ab(18'h33333, 0, 1, "R4");
    chk("R4 hold strobe high", b_out, 18'h0F0F0);
    step_ab(18'h0ABCD, 0, 0, "R5");
    step_ab(18'h35555, 0, 0, "R5");
    chk("R5 falling strobe captures", b_out, 18'h0ABCD);
    step_ab(18'h01234, 1, 1, "R6");
    step_ab(18'h04321, 1, 0, "R6");
    step_ab(18'h3C3C3, 0, 0, "R6");
    chk("R6 fall during pass ignored", b_out, 18'h04321);

    step_ba(18'h1CAFE, 1, 0, "R8");
    chk("R8 bypass", a_out, 18'h1CAFE);
    step_ba(18'h00F00, 0, 1, "R8");
    chk("R8 keeps last pass sample", a_out, 18'h1CAFE);
    step_ba(18'h2D00D, 0, 0, "R8");
    step_ba(18'h3FFFF, 0, 0, "R8");
    chk("R8 falling strobe captures", a_out, 18'h2D00D);
    chk("R10 A-to-B untouched", b_out, 18'h04321);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ab_oe = k[0]; ba_oe_n = k[1];
      #2;
      chk("R7 b_drive polarity", W'(b_drive), W'(k[0]));
      chk("R9 a_drive polarity", W'(a_drive), W'(!k[1]));
    end

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      a_in = W'($urandom); b_in = W'($urandom);
      ab_pass = ($urandom % 4) == 0; ba_pass = ($urandom % 4) == 0;
      ab_strobe = $urandom; ba_strobe = $urandom;
      ab_oe = $urandom; ba_oe_n = $urandom;
      #2 check_all("R10 random");
    end

    done = 1;
    $display("note: cycles with both ports driving (contention if tied): %0d", contention);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule